// File: doc/BRIEF.md
# Clocked Multi-Input Muller C-Element Cascade

This block is a Muller C-element gate with N+1 inputs, modelled on a clock. Its output rises only once every effective input is high, falls only once every effective input is low, and keeps its value while the effective inputs disagree. Each raw input whose index is above a split point J is inverted before it is used, so those inputs act as active-low requests. Inputs 0 to J are used as they are. The order in which the inputs arrive makes no difference.

The gate is built as a chain of two-input C-element stages. Each stage holds its value in a register that updates on the rising clock edge. The first stage combines effective inputs 0 and 1. Each later stage k combines the output of stage k-1 with effective input k. An asynchronous active-low reset puts every stage at the value INIT, and the surroundings must hold the inputs at the matching levels: raw bits 0 to J equal to INIT and raw bits above J equal to the inverse of INIT.

A monitor watches for one fault in the surroundings. The fault is an input that returns to its old level after it has moved away from the output, before the output has followed it. When this happens the monitor raises a flag for one cycle.

Top module: `celem_cascade`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, `out_q` equals INIT and `withdraw_err` is 0.
- R2: The effective value of raw input i is `in_raw[i]` when i <= J and `~in_raw[i]` when i > J. With the defaults N=3 and J=1, bits 2 and 3 are inverted.
- R3: Start from a settled state where every effective input equals `out_q`. If every effective input then takes the opposite value and holds it for N+1 cycles, `out_q` has taken that value.
- R4: Start from a settled state where every effective input equals `out_q`. If the effective inputs move to a pattern where some bits are 0 and some are 1, `out_q` keeps its value.
- R5: Start from a settled state. If all effective inputs flip in the same cycle, `out_q` keeps its old value through the first N-1 rising edges and takes the new value on the Nth rising edge. Whenever `out_q` changes, its new value equals the value effective input N had in the cycle before the change.
- R6: When the effective inputs move one at a time toward the opposite value, in either ascending or descending index order, `out_q` stays put until the last input has moved. It changes only after that.
- R7: Suppose an effective input was sampled at a value different from `out_q`, and then changes while `out_q` has not yet taken that value. Then `withdraw_err` is 1 for exactly the one cycle after the rising edge that samples the change.
- R8: An input sequence where each input changes only while its sampled value equals `out_q` never raises `withdraw_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every stage samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads INIT into every stage |
| in_raw | input | N+1 | Raw inputs; bits above J are inverted before use |
| out_q | output | 1 | C-element output, the last stage of the chain |
| withdraw_err | output | 1 | One-cycle flag: an input was withdrawn before the output followed it |

## Verification
The main check is a sweep. For each starting output value, every one of the 2^(N+1) effective input patterns is applied from a settled state, and the expected output is worked out arithmetically. Only the single pattern with every bit flipped may move the output; every mixed pattern must hold it. This separates correct all-input agreement from gates that fire on partial agreement or on one input. Other runs apply the inputs simultaneously, in ascending order and in descending order, which tests the exact N-edge latency and that arrival order does not matter. Raw patterns that differ only above J test the inversion split. An early withdrawal and a late withdrawal, the late one made after all inputs have agreed but before the output responds, both test the monitor. The ordered runs confirm that the monitor stays quiet when the surroundings follow the rules.

// File: rtl/celem_pkg.sv
// Package: celem_pkg
// Shared helpers for the clocked C-element cascade.
// Assumes: single-bit operands; a stage's hold value is its own register.
package celem_pkg;

    // Next state of a two-input C-element: follow the inputs when they agree, else hold.
    function automatic logic c_next(input logic a, input logic b, input logic hold);
        return (a == b) ? a : hold;
    endfunction

    // Inversion mask: bit i is set when i lies above the split index.
    function automatic logic [63:0] inv_mask(input int unsigned width, input int unsigned split);
        logic [63:0] m;
        m = '0;
        for (int unsigned i = 0; i < width; i++) begin
            if (i > split) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/celem_input_map.sv
// Module: celem_input_map
// Turns raw inputs into effective inputs. Bits above SPLIT are inverted and the
// others pass through unchanged.
// Assumes: 0 <= SPLIT <= W-1; purely combinational.
module celem_input_map #(
    parameter int W     = 4,
    parameter int SPLIT = 1
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] eff_o
);
    // One buffer or inverter per bit, chosen at elaboration time.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i > SPLIT) begin : g_inv
            assign eff_o[i] = ~raw_i[i];
        end else begin : g_pass
            assign eff_o[i] = raw_i[i];
        end
    end
endmodule

// File: rtl/celem_stage.sv
// Module: celem_stage
// One registered two-input C-element. When both operands agree it loads their
// value on the rising edge; otherwise it keeps its value.
// Assumes: asynchronous active-low reset loads INIT.
module celem_stage
    import celem_pkg::*;
#(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic q_o
);
    // State register of the stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= INIT;
        else        q_o <= c_next(a_i, b_i, q_o);
    end
endmodule

// File: rtl/celem_withdraw_mon.sv
// Module: celem_withdraw_mon
// Raises a one-cycle flag when an effective input that had moved away from the
// output changes again before the output has followed it.
// Assumes: the effective inputs and the output come from the same clock domain.
module celem_withdraw_mon #(
    parameter int   W    = 4,
    parameter logic INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] eff_i,
    input  logic         out_i,
    output logic         err_o
);
    logic [W-1:0] eff_q;
    logic [W-1:0] pending;
    logic [W-1:0] moved;

    // Bits whose last sample differed from the output, and bits that changed since that sample.
    always_comb begin
        pending = eff_q ^ {W{out_i}};
        moved   = eff_q ^ eff_i;
    end

    // Keep the previous sample and register the violation flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_q <= {W{INIT}};
            err_o <= 1'b0;
        end else begin
            eff_q <= eff_i;
            err_o <= |(pending & moved);
        end
    end
endmodule

// File: rtl/celem_cascade.sv
// Module: celem_cascade
// An (N+1)-input C-element built as a chain of N registered two-input stages.
// Inputs above J are inverted. A monitor flags early withdrawals.
// Assumes: N >= 1, 0 <= J <= N. At reset the surroundings hold the inputs at
// levels that match INIT (effective inputs equal to INIT).
module celem_cascade #(
    parameter int   N    = 3,
    parameter int   J    = 1,
    parameter logic INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N:0]   in_raw,
    output logic         out_q,
    output logic         withdraw_err
);
    localparam int W = N + 1;

    logic [W-1:0] eff;
    logic [N:1]   stage_q;

    // Apply the inversion split.
    celem_input_map #(.W(W), .SPLIT(J)) i_map (
        .raw_i (in_raw),
        .eff_o (eff)
    );

    // Chain of stages: stage 1 takes inputs 0 and 1, stage k takes stage k-1 and input k.
    for (genvar k = 1; k <= N; k++) begin : g_chain
        if (k == 1) begin : g_first
            celem_stage #(.INIT(INIT)) i_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .a_i   (eff[0]),
                .b_i   (eff[1]),
                .q_o   (stage_q[1])
            );
        end else begin : g_next
            celem_stage #(.INIT(INIT)) i_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .a_i   (stage_q[k-1]),
                .b_i   (eff[k]),
                .q_o   (stage_q[k])
            );
        end
    end

    // The output is the last stage of the chain.
    assign out_q = stage_q[N];

    // Watch the surroundings for inputs withdrawn too early.
    celem_withdraw_mon #(.W(W), .INIT(INIT)) i_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .eff_i (eff),
        .out_i (out_q),
        .err_o (withdraw_err)
    );
endmodule

// File: rtl/celem_cascade_chk.sv
// Module: celem_cascade_chk
// Property checker for celem_cascade, attached with a bind statement.
// Assumes: the same parameters as the design it watches.
module celem_cascade_chk
    import celem_pkg::*;
#(
    parameter int   N    = 3,
    parameter int   J    = 1,
    parameter logic INIT = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [N:0] in_raw,
    input logic       out_q,
    input logic       withdraw_err
);
    localparam logic [63:0] MASK = inv_mask(N + 1, J);

    logic [N:0] eff_c;

    // Effective inputs, recomputed on the checker's side.
    always_comb eff_c = in_raw ^ MASK[N:0];

    // R1: the first cycle after reset release shows the initial state.
    a_r1_reset_out: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_q == INIT));
    a_r1_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !withdraw_err);

    // R5: the output moves only to the value effective input N held in the cycle before.
    a_r5_follow_last: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> ($past(eff_c[N]) == out_q));

    // R7: a flag needs an input change between the two preceding samples.
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (withdraw_err && $past(rst_n, 2)) |-> ($past(in_raw) != $past(in_raw, 2)));
endmodule

bind celem_cascade celem_cascade_chk #(.N(N), .J(J), .INIT(INIT)) i_chk (.*);

// File: tb/test_celem_cascade.sv
// Bench for celem_cascade: sweeps every effective pattern from both settled
// states and runs the latency, order, inversion and withdrawal scenarios.
module test_celem_cascade;
    localparam int   N    = 3;
    localparam int   J    = 1;
    localparam logic INIT = 1'b0;
    localparam int   W    = N + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_raw;
    logic         out_q;
    logic         withdraw_err;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;
    bit watch  = 1'b0;
    int flag_seen = 0;

    celem_cascade #(.N(N), .J(J), .INIT(INIT)) i_celem_cascade (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_raw       (in_raw),
        .out_q        (out_q),
        .withdraw_err (withdraw_err)
    );

    always #5 clk = ~clk;

    // Bits above J are active-low (R2).
    function automatic logic [W-1:0] mask_of();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = (i > J);
        return m;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_eff(input logic [W-1:0] e);
        in_raw = e ^ mask_of();
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input logic v);
        drive_eff({W{v}});
        ticks(N + 2);
    endtask

    // Count flags while a legal sequence runs.
    always @(negedge clk) if (watch && withdraw_err) flag_seen++;

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] e;
        drive_eff({W{INIT}});
        ticks(3);
        check("R1 out in reset", out_q, INIT);
        check("R1 flag in reset", withdraw_err, 1'b0);
        rst_n = 1'b1;
        ticks(1);
        check("R1 out after release", out_q, INIT);
        check("R1 flag after release", withdraw_err, 1'b0);

        // R3/R4 sweep over all effective patterns from both settled values.
        for (int b = 0; b < 2; b++) begin
            settle(logic'(b));
            for (int p = 0; p < (1 << W); p++) begin
                logic exp;
                drive_eff(W'(p));
                ticks(N + 1);
                exp = (W'(p) == {W{~logic'(b)}}) ? ~logic'(b) : logic'(b);
                if (exp != logic'(b)) check("R3 full flip", out_q, exp);
                else                  check("R4 mixed hold", out_q, exp);
                settle(logic'(b));
            end
        end

        // R5 latency, rising then falling, with no flags expected (R8).
        settle(1'b0);
        watch = 1'b1;
        drive_eff({W{1'b1}});
        for (int k = 1; k <= N; k++) begin
            ticks(1);
            check("R5 rise latency", out_q, (k >= N));
        end
        ticks(2);
        drive_eff({W{1'b0}});
        for (int k = 1; k <= N; k++) begin
            ticks(1);
            check("R5 fall latency", out_q, !(k >= N));
        end
        ticks(2);

        // R6 ascending order toward 1, then descending order toward 0.
        e = '0;
        for (int i = 0; i < W; i++) begin
            e[i] = 1'b1;
            drive_eff(e);
            ticks(N + 1);
            check("R6 ascending", out_q, (i == W - 1));
        end
        for (int i = W - 1; i >= 0; i--) begin
            e[i] = 1'b0;
            drive_eff(e);
            ticks(N + 1);
            check("R6 descending", out_q, (i != 0));
        end
        watch = 1'b0;
        check("R8 no flag on legal runs", (flag_seen != 0), 1'b0);

        // R2: raw all ones gives a mixed pattern; raw ones below the split only gives all ones.
        settle(1'b0);
        in_raw = '1;
        ticks(N + 1);
        check("R2 raw ones hold", out_q, 1'b0);
        for (int i = 0; i < W; i++) in_raw[i] = (i <= J);
        ticks(N + 1);
        check("R2 split rise", out_q, 1'b1);

        // R7 early withdrawal of input 0.
        settle(1'b0);
        drive_eff(W'(1));
        ticks(1);
        check("R7 no flag on advance", withdraw_err, 1'b0);
        ticks(1);
        drive_eff('0);
        ticks(1);
        check("R7 flag on withdraw", withdraw_err, 1'b1);
        ticks(1);
        check("R7 flag one cycle", withdraw_err, 1'b0);

        // R7 late withdrawal: all inputs agreed, one drops before the output responds.
        settle(1'b0);
        drive_eff('1);
        ticks(1);
        drive_eff({{(W-1){1'b1}}, 1'b0});
        ticks(1);
        check("R7 late withdraw flag", withdraw_err, 1'b1);
        settle(1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule